// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects a vector of maskable interrupt request lines and presents at most one of them at a time to a processor. Each source has a mask bit and a three-bit priority level, both set through a small write port. A one-cycle pulse on a request line marks that source as waiting. The waiting flag persists through masking, through the processor's interrupt-disable and non-maskable-service states, and through lower-priority servicing. It is dropped only when that source is acknowledged.

The winner is the unmasked waiting source with the numerically smallest level (level 0 is the most urgent). Among sources at the same level, the smallest source index wins. The chosen source is shown on a registered request port and stays there unchanged until the processor acknowledges it.

Each acknowledge pushes the granted level onto an eight-entry in-service stack, and an end-of-interrupt strobe pops it. While the stack holds entries, only a source whose level is strictly more urgent than the top entry can be presented. The processor's interrupt-disable flag and its non-maskable-service flag arrive as inputs. While either is set, no new request is offered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, no source is waiting, every source is masked with level 7, the in-service stack is empty and `req_valid` is 0.
- R2: A one-cycle pulse on `irq_in[i]` marks source i waiting. A masked waiting source is never presented, but it stays waiting and is presented once it is unmasked.
- R3: Among eligible sources, the one with the numerically smallest level is presented (level 0 is the most urgent, level 7 the least).
- R4: Among eligible sources at the same level, the one with the smallest index is presented.
- R5: While `cpu_id` or `cpu_np` is 1, no new request is loaded onto the request port. Arbitration resumes once both are 0.
- R6: While `req_valid` is 1 and `ack` is 0, `req_valid`, `req_index` and `req_level` stay unchanged, even if a more urgent source becomes waiting.
- R7: `ack` while `req_valid` is 1 clears `req_valid` and the waiting flag of the presented source at the same clock edge. That source is not offered again without a new pulse.
- R8: While the in-service stack is non-empty, only a source whose level is strictly smaller than the top stacked level can be presented. A source at an equal or larger level waits.
- R9: `eoi` pops the top in-service level. The nesting threshold then returns to the level below it, or is lifted entirely when the stack becomes empty.
- R10: `cfg_we` writes `cfg_mask` (1 = masked) and `cfg_level` into the control entry of source `cfg_idx`. A waiting source is presented with its current level on `req_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Request pulses, one bit per source |
| cfg_we | input | 1 | Control entry write strobe |
| cfg_idx | input | IDX_W | Source whose control entry is written |
| cfg_mask | input | 1 | Mask value to write (1 = masked) |
| cfg_level | input | 3 | Priority level to write (0 most urgent) |
| cpu_id | input | 1 | Processor interrupt-disable flag |
| cpu_np | input | 1 | Processor non-maskable-service flag |
| ack | input | 1 | Acknowledge of the presented request |
| eoi | input | 1 | End of the innermost serviced interrupt |
| req_valid | output | 1 | A request is presented |
| req_index | output | IDX_W | Index of the presented source |
| req_level | output | 3 | Level of the presented source |

## Verification
The bench builds the block with its default parameters: 59 sources, a 6-bit index and an 8-deep in-service stack. With 59 sources, the same-level tie-break is tested between indices far apart as well as near each other. The full level range of 0 to 7 lets two-deep nesting, equal-level blocking and the return of the threshold after each pop be reached with only a few sources. A stack of eight matches the eight levels, so the overflow guard is checked against the deepest nesting the level compare allows.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int THR_W   = LVL_W + 1;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [THR_W-1:0] thr_t;

    // control entry for one source
    typedef struct packed {
        logic masked;
        lvl_t level;
    } src_cfg_t;

    localparam src_cfg_t CFG_RESET = '{masked: 1'b1, level: lvl_t'(NUM_LVL - 1)};

    // threshold seen by arbitration: above every level when nothing is in service
    function automatic thr_t make_thr(input logic stack_empty, input lvl_t top);
        return stack_empty ? thr_t'(NUM_LVL) : {1'b0, top};
    endfunction

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
    import irqc_pkg::*;
#(
    parameter int N_SRC = 59,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SRC-1:0]     irq_in,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  src_cfg_t             cfg_wdata,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    output logic [N_SRC-1:0]     pend_q,
    output src_cfg_t [N_SRC-1:0] cfg_q
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic hit_cfg;
        logic hit_clr;
        assign hit_cfg = cfg_we && (cfg_idx == IDX_W'(g));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
                cfg_q[g]  <= CFG_RESET;
            end else begin
                if (hit_cfg) begin
                    cfg_q[g] <= cfg_wdata;
                end
                pend_q[g] <= (pend_q[g] && !hit_clr) || irq_in[g];
            end
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int N_SRC = 59,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]     pend,
    input  src_cfg_t [N_SRC-1:0] cfg,
    input  thr_t                 thr,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output lvl_t                 win_lvl
);

    logic [N_SRC-1:0] elig;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = pend[g] && !cfg[g].masked && ({1'b0, cfg[g].level} < thr);
    end

    // scan from the top index down: "<=" lets a lower index take over on ties
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = lvl_t'(NUM_LVL - 1);
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!win_valid || cfg[i].level <= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = cfg[i].level;
            end
        end
    end

endmodule

// File: rtl/irqc_level_stack.sv
module irqc_level_stack
    import irqc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  lvl_t push_lvl,
    input  logic pop,
    output logic empty,
    output lvl_t top_lvl
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    lvl_t [DEPTH-1:0] slot_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] top_ptr;
    logic [PTR_W-1:0] push_ptr;

    assign empty    = (cnt_q == '0);
    assign top_ptr  = PTR_W'(cnt_q - 1'b1);
    assign push_ptr = PTR_W'(cnt_q);
    assign top_lvl  = empty ? lvl_t'(NUM_LVL - 1) : slot_q[top_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10: begin
                    slot_q[push_ptr] <= push_lvl;
                    cnt_q            <= cnt_q + 1'b1;
                end
                2'b01: begin
                    if (!empty) cnt_q <= cnt_q - 1'b1;
                end
                2'b11: begin
                    // pop first, then push: the top slot is replaced
                    if (empty) begin
                        slot_q[0] <= push_lvl;
                        cnt_q     <= CNT_W'(1);
                    end else begin
                        slot_q[top_ptr] <= push_lvl;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (cnt_q < CNT_W'(DEPTH))); // R8

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC     = 59,
    parameter int STK_DEPTH = 8,
    parameter int IDX_W     = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_in,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_mask,
    input  logic [2:0]       cfg_level,
    input  logic             cpu_id,
    input  logic             cpu_np,
    input  logic             ack,
    input  logic             eoi,
    output logic             req_valid,
    output logic [IDX_W-1:0] req_index,
    output logic [2:0]       req_level
);

    logic [N_SRC-1:0]     pend_q;
    src_cfg_t [N_SRC-1:0] cfg_q;
    src_cfg_t             cfg_wdata;
    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    lvl_t                 win_lvl;
    logic                 stk_empty;
    lvl_t                 stk_top;
    thr_t                 thr;
    logic                 ack_fire;
    logic                 load;

    logic                 rv_q;
    logic [IDX_W-1:0]     ri_q;
    lvl_t                 rl_q;

    assign cfg_wdata = '{masked: cfg_mask, level: lvl_t'(cfg_level)};
    assign ack_fire  = ack && rv_q;
    assign load      = !rv_q && !cpu_id && !cpu_np && win_valid;
    assign thr       = make_thr(stk_empty, stk_top);

    irqc_src_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .clr_en    (ack_fire),
        .clr_idx   (ri_q),
        .pend_q    (pend_q),
        .cfg_q     (cfg_q)
    );

    irqc_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
        .pend      (pend_q),
        .cfg       (cfg_q),
        .thr       (thr),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    irqc_level_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (ack_fire),
        .push_lvl (rl_q),
        .pop      (eoi),
        .empty    (stk_empty),
        .top_lvl  (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q <= 1'b0;
            ri_q <= '0;
            rl_q <= '0;
        end else if (ack_fire) begin
            rv_q <= 1'b0;
        end else if (load) begin
            rv_q <= 1'b1;
            ri_q <= win_idx;
            rl_q <= win_lvl;
        end
    end

    assign req_valid = rv_q;
    assign req_index = ri_q;
    assign req_level = 3'(rl_q);

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ack) |=> (req_valid && $stable(req_index) && $stable(req_level))); // R6

    AST_GATED_BY_CPU: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && (cpu_id || cpu_np)) |=> !req_valid); // R5

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ack) |=> !req_valid); // R7

    AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ack && !irq_in[req_index]) |=> !pend_q[$past(req_index)]); // R7

    AST_STRICT_NEST: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> ($past(stk_empty) || (req_level < 3'($past(stk_top))))); // R8

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (int'(req_index) < N_SRC)); // R4

endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

    localparam int N     = 59;
    localparam int IW    = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_in;
    logic          cfg_we;
    logic [IW-1:0] cfg_idx;
    logic          cfg_mask;
    logic [2:0]    cfg_level;
    logic          cpu_id;
    logic          cpu_np;
    logic          ack;
    logic          eoi;
    logic          req_valid;
    logic [IW-1:0] req_index;
    logic [2:0]    req_level;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N), .STK_DEPTH(8)) u_prio_irq_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cpu_id(cpu_id), .cpu_np(cpu_np),
        .ack(ack), .eoi(eoi), .req_valid(req_valid), .req_index(req_index),
        .req_level(req_level)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int idx, input logic m, input int lvl);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_mask = m; cfg_level = 3'(lvl);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse2(input int a, input int b);
        @(negedge clk);
        irq_in[a] = 1'b1; irq_in[b] = 1'b1;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic pulse(input int a);
        pulse2(a, a);
    endtask

    // processor model: acknowledge sets its interrupt-disable flag
    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1; cpu_id = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic expect_req(input string tag, input int idx, input int lvl);
        check({tag, " valid"}, int'(req_valid), 1);
        check({tag, " index"}, int'(req_index), idx);
        check({tag, " level"}, int'(req_level), lvl);
    endtask

    task automatic finish_one();
        do_ack();
        do_eoi();
        cpu_id = 1'b0;
        cycles(2);
    endtask

    task automatic t_reset_and_mask();
        check("R1 idle after reset", int'(req_valid), 0);
        pulse(3);
        cycles(4);
        check("R1 masked at reset", int'(req_valid), 0);
        cfg(3, 1'b0, 6);
        cycles(2);
        expect_req("R2 unmask serves pending", 3, 6);
        do_ack();
        check("R7 ack drops valid", int'(req_valid), 0);
        do_eoi();
        cpu_id = 1'b0;
        cycles(4);
        check("R7 not re-presented", int'(req_valid), 0);
    endtask

    task automatic t_priority();
        cfg(10, 1'b0, 2);
        cfg(5, 1'b0, 4);
        pulse2(10, 5);
        cycles(2);
        expect_req("R3 smaller level wins", 10, 2);
        do_ack();
        cpu_id = 1'b0;
        cycles(4);
        check("R8 less urgent blocked", int'(req_valid), 0);
        do_eoi();
        cycles(2);
        expect_req("R9 pop lifts threshold", 5, 4);
        finish_one();
    endtask

    task automatic t_tie();
        cfg(20, 1'b0, 3);
        cfg(7, 1'b0, 3);
        pulse2(20, 7);
        cycles(2);
        expect_req("R4 lower index wins", 7, 3);
        finish_one();
        expect_req("R4 other served next", 20, 3);
        finish_one();
    endtask

    task automatic t_gate();
        cpu_np = 1'b1;
        cfg(1, 1'b0, 1);
        pulse(1);
        cycles(4);
        check("R5 held by np", int'(req_valid), 0);
        cpu_np = 1'b0; cpu_id = 1'b1;
        cycles(4);
        check("R5 held by id", int'(req_valid), 0);
        cpu_id = 1'b0;
        cycles(2);
        expect_req("R5 resumes", 1, 1);
        finish_one();
    endtask

    task automatic t_hold_and_nest();
        cfg(30, 1'b0, 5);
        cfg(2, 1'b0, 0);
        pulse(30);
        cycles(2);
        expect_req("R6 first", 30, 5);
        pulse(2);
        cycles(3);
        expect_req("R6 stable until ack", 30, 5);
        do_ack();
        cpu_id = 1'b0;
        cycles(2);
        expect_req("R8 strictly higher nests", 2, 0);
        do_ack();
        do_eoi();
        do_eoi();
        cpu_id = 1'b0;
        cycles(4);
        check("R9 nothing left", int'(req_valid), 0);
    endtask

    task automatic t_equal_level();
        cfg(40, 1'b0, 3);
        cfg(41, 1'b0, 3);
        pulse(40);
        cycles(2);
        expect_req("R8 outer", 40, 3);
        do_ack();
        cpu_id = 1'b0;
        pulse(41);
        cycles(4);
        check("R8 equal level no nest", int'(req_valid), 0);
        do_eoi();
        cycles(2);
        expect_req("R9 equal served after pop", 41, 3);
        finish_one();
    endtask

    task automatic t_reconfig();
        cfg(50, 1'b1, 4);
        pulse(50);
        cycles(4);
        check("R2 masked stays quiet", int'(req_valid), 0);
        cfg(50, 1'b0, 6);
        cycles(2);
        expect_req("R10 new level shown", 50, 6);
        finish_one();
    endtask

    initial begin
        rst = 1'b1; irq_in = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_mask = 1'b0;
        cfg_level = '0; cpu_id = 1'b0; cpu_np = 1'b0; ack = 1'b0; eoi = 1'b0;
        cycles(3);
        rst = 1'b0;
        cycles(1);
        t_reset_and_mask();
        t_priority();
        t_tie();
        t_gate();
        t_hold_and_nest();
        t_equal_level();
        t_reconfig();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule